// File: doc/BRIEF.md
# Barrel Shifter with Architectural Carry

This block shifts an N-bit operand (N is 32 or 64, set by a parameter) by a variable amount. A 2-bit select chooses one of four kinds: logical left, logical right, arithmetic right or rotate right. Alongside the shifted value it returns a carry bit, which each kind derives by its own rule. For the three plain shifts the carry is the last bit moved out of the operand. For rotate it is the top bit of the rotated value.

A shift amount of zero returns the operand untouched. In that case the carry-valid output drops low, so surrounding flag logic keeps its previous carry. Amounts at or beyond N behave in a defined way:
- Logical shifts give a zero result.
- Arithmetic right shift fills the result with the sign bit.
- Rotate reduces the amount modulo N.

By default the three outputs pass through one register stage, which gives a latency of one clock. With that stage turned off by a parameter, the block is purely combinational.

Top module: `shf_unit`

## Requirements
- R1: An amount of zero returns the operand unchanged, with carry_valid low and carry low, for every kind.
- R2: Logical left (op 2'b00) by k with 1 <= k < N gives the operand shifted up by k, filled with zeros. The carry is operand bit N-k.
- R3: Logical right (op 2'b01) by k with 1 <= k < N gives the operand shifted down by k, filled with zeros. The carry is operand bit k-1.
- R4: Arithmetic right (op 2'b10) by k with 1 <= k < N shifts down and fills with copies of the operand MSB. The carry is operand bit k-1.
- R5: Rotate right (op 2'b11) by k != 0 rotates by k mod N. The carry equals the MSB of the rotated result.
- R6: A logical shift by exactly N gives a zero result. The carry is the last bit shifted out: operand bit 0 for left, operand bit N-1 for right.
- R7: A logical shift by more than N gives a zero result and a zero carry.
- R8: Arithmetic right by N or more gives every result bit equal to the operand MSB, and the carry equals that MSB.
- R9: Rotate by a nonzero multiple of N returns the operand with carry_valid high and carry equal to operand MSB.
- R10: carry_valid is high exactly when the amount is nonzero.
- R11: With the output stage enabled, outputs show the inputs of the previous rising clock edge. They hold between edges, and reset clears them all to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand | input | N | Value to be shifted |
| amount | input | AW | Shift amount, unsigned |
| op | input | 2 | Kind: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| result | output | N | Shifted value |
| carry | output | 1 | Carry-out per the selected kind |
| carry_valid | output | 1 | High when the carry is meaningful (nonzero amount) |

## Verification
The bound checker looks at every cycle. It checks that a zero amount passes the operand through with no carry, and that carry_valid tracks the amount. It also checks that rotate carry matches the result MSB, that far logical shifts clear both result and carry, and that far arithmetic shifts replicate the sign. The directed scenarios are what show the exact bit positions of the carry for in-range shifts. They also cover the amount-equals-N boundary, rotate wraparound by multiples of N, and the one-cycle latency and reset value of the output stage.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHF_LSL = 2'b00,
    SHF_LSR = 2'b01,
    SHF_ASR = 2'b10,
    SHF_ROR = 2'b11
  } shf_op_e;
endpackage

// File: rtl/shf_datapath.sv
module shf_datapath #(
  parameter int N  = 32,
  parameter int AW = 8
) (
  input  logic [N-1:0]  operand,
  input  logic [AW-1:0] amount,
  input  logic [1:0]    op,
  output logic [N-1:0]  res
);
  import shf_pkg::*;
  localparam int LW = $clog2(N);
  localparam logic [LW:0] NW = (LW+1)'(N);

  logic [LW-1:0]       rot_m;
  logic [LW:0]         rot_l;
  logic signed [N-1:0] op_s;
  logic [N-1:0]        sh_l, sh_r, sh_a, sh_rot;

  always_comb begin
    rot_m  = amount[LW-1:0];
    rot_l  = NW - {1'b0, rot_m};
    op_s   = $signed(operand);
    sh_l   = operand << amount;
    sh_r   = operand >> amount;
    sh_a   = op_s >>> amount;
    sh_rot = (operand >> rot_m) | (operand << rot_l);
    if (amount == '0) begin
      res = operand;
    end else begin
      unique case (shf_op_e'(op))
        SHF_LSL: res = sh_l;
        SHF_LSR: res = sh_r;
        SHF_ASR: res = sh_a;
        default: res = sh_rot;
      endcase
    end
  end
endmodule

// File: rtl/shf_carry.sv
module shf_carry #(
  parameter int N  = 32,
  parameter int AW = 8
) (
  input  logic [N-1:0]  operand,
  input  logic [AW-1:0] amount,
  input  logic [1:0]    op,
  input  logic          rot_msb,
  output logic          carry,
  output logic          carry_vld
);
  import shf_pkg::*;

  logic [N:0]        ext_r, ext_l;
  logic signed [N:0] ext_a_in, ext_a;

  always_comb begin
    ext_r    = {operand, 1'b0} >> amount;
    ext_l    = {1'b0, operand} << amount;
    ext_a_in = $signed({operand, 1'b0});
    ext_a    = ext_a_in >>> amount;
    carry_vld = (amount != '0);
    if (!carry_vld) begin
      carry = 1'b0;
    end else begin
      unique case (shf_op_e'(op))
        SHF_LSL: carry = ext_l[N];
        SHF_LSR: carry = ext_r[0];
        SHF_ASR: carry = ext_a[0];
        default: carry = rot_msb;
      endcase
    end
  end
endmodule

// File: rtl/shf_outreg.sv
module shf_outreg #(
  parameter int N       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_res,
  input  logic         d_carry,
  input  logic         d_vld,
  output logic [N-1:0] q_res,
  output logic         q_carry,
  output logic         q_vld
);
  generate
    if (REG_OUT) begin : g_reg
      logic [N-1:0] res_q, res_d;
      logic         carry_q, carry_d, vld_q, vld_d;

      always_comb begin
        res_d   = d_res;
        carry_d = d_carry;
        vld_d   = d_vld;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q   <= '0;
          carry_q <= 1'b0;
          vld_q   <= 1'b0;
        end else begin
          res_q   <= res_d;
          carry_q <= carry_d;
          vld_q   <= vld_d;
        end
      end

      assign q_res   = res_q;
      assign q_carry = carry_q;
      assign q_vld   = vld_q;
    end else begin : g_comb
      assign q_res   = d_res;
      assign q_carry = d_carry;
      assign q_vld   = d_vld;
    end
  endgenerate
endmodule

// File: rtl/shf_unit.sv
module shf_unit #(
  parameter int N       = 32,
  parameter int AW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  operand,
  input  logic [AW-1:0] amount,
  input  logic [1:0]    op,
  output logic [N-1:0]  result,
  output logic          carry,
  output logic          carry_valid
);
  logic [N-1:0] dp_res;
  logic         cy, cy_vld;

  shf_datapath #(.N(N), .AW(AW)) u_dp (
    .operand (operand),
    .amount  (amount),
    .op      (op),
    .res     (dp_res)
  );

  shf_carry #(.N(N), .AW(AW)) u_cy (
    .operand   (operand),
    .amount    (amount),
    .op        (op),
    .rot_msb   (dp_res[N-1]),
    .carry     (cy),
    .carry_vld (cy_vld)
  );

  shf_outreg #(.N(N), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_res   (dp_res),
    .d_carry (cy),
    .d_vld   (cy_vld),
    .q_res   (result),
    .q_carry (carry),
    .q_vld   (carry_valid)
  );
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
  parameter int N       = 32,
  parameter int AW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  operand,
  input logic [AW-1:0] amount,
  input logic [1:0]    op,
  input logic [N-1:0]  result,
  input logic          carry,
  input logic          carry_valid
);
  generate
    if (REG_OUT) begin : g_chk
      logic seen;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
      end

      // R1
      p_zero_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(amount) == '0) |->
          (result == $past(operand) && !carry_valid && !carry));

      // R10
      p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (carry_valid == ($past(amount) != '0)));

      // R5
      p_ror_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(op) == 2'b11 && $past(amount) != '0) |->
          (carry == result[N-1]));

      // R7
      p_logic_far_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(op[1]) == 1'b0 && $past(amount) > N) |->
          (result == '0 && !carry));

      // R8
      p_asr_far_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(op) == 2'b10 && $past(amount) >= N) |->
          (result == {N{$past(operand[N-1])}} && carry == $past(operand[N-1])));
    end
  endgenerate
endmodule

bind shf_unit shf_unit_chk #(.N(N), .AW(AW), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/shf_unit_test.sv
module shf_unit_test;
  localparam int N  = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  operand;
  logic [AW-1:0] amount;
  logic [1:0]    op;
  logic [N-1:0]  result;
  logic          carry;
  logic          carry_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  shf_unit #(.N(N), .AW(AW), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .operand(operand), .amount(amount), .op(op),
    .result(result), .carry(carry), .carry_valid(carry_valid)
  );

  always #5 clk = ~clk;

  // Bit-by-bit reference from the requirements
  task automatic model(input logic [1:0] o, input int a, input logic [N-1:0] x,
                       output logic [N-1:0] r, output logic c, output logic v);
    r = '0; c = 1'b0; v = (a != 0);
    if (a == 0) begin
      r = x;
    end else if (o == 2'b00) begin
      for (int i = 0; i < N; i++) r[i] = (i - a >= 0) ? x[i-a] : 1'b0;
      c = (a <= N) ? x[N-a] : 1'b0;
    end else if (o == 2'b01) begin
      for (int i = 0; i < N; i++) r[i] = (i + a < N) ? x[i+a] : 1'b0;
      c = (a <= N) ? x[a-1] : 1'b0;
    end else if (o == 2'b10) begin
      for (int i = 0; i < N; i++) r[i] = (i + a < N) ? x[i+a] : x[N-1];
      c = (a <= N) ? x[a-1] : x[N-1];
    end else begin
      for (int i = 0; i < N; i++) r[i] = x[(i + a) % N];
      c = r[N-1];
    end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [1:0] o, input int a,
                     input logic [N-1:0] x);
    logic [N-1:0] er; logic ec, ev;
    @(negedge clk);
    op = o; amount = AW'(a); operand = x;
    @(negedge clk);
    model(o, a, x, er, ec, ev);
    chk(req, "result", result, er);
    chk(req, "carry", {{(N-1){1'b0}}, carry}, {{(N-1){1'b0}}, ec});
    chk("R10", "carry_valid", {{(N-1){1'b0}}, carry_valid}, {{(N-1){1'b0}}, ev});
  endtask

  localparam logic [N-1:0] PAT0 = 32'h8000_0001;
  localparam logic [N-1:0] PAT1 = 32'hA5C3_0F69;
  localparam logic [N-1:0] PAT2 = 32'h7FFF_FFFE;
  localparam logic [N-1:0] PAT3 = 32'hF00D_1234;

  task automatic t_reset;
    operand = PAT1; amount = 8'd3; op = 2'b00;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    #1;
    chk("R11", "reset result", result, '0);
    chk("R11", "reset flags", {{(N-2){1'b0}}, carry, carry_valid}, '0);
    @(negedge clk);
    chk("R11", "held in reset", result, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_zero;
    for (int o = 0; o < 4; o++) begin
      run("R1", 2'(o), 0, PAT1);
      run("R1", 2'(o), 0, PAT0);
    end
  endtask

  task automatic t_lsl;
    for (int a = 1; a < N; a += 3) begin
      run("R2", 2'b00, a, PAT1);
      run("R2", 2'b00, a, PAT3);
    end
    run("R2", 2'b00, N - 1, PAT0);
  endtask

  task automatic t_lsr;
    for (int a = 1; a < N; a += 3) begin
      run("R3", 2'b01, a, PAT1);
      run("R3", 2'b01, a, PAT2);
    end
    run("R3", 2'b01, 1, PAT0);
  endtask

  task automatic t_asr;
    for (int a = 1; a < N; a += 4) begin
      run("R4", 2'b10, a, PAT3);
      run("R4", 2'b10, a, PAT2);
    end
  endtask

  task automatic t_ror;
    for (int a = 1; a < N; a += 5) begin
      run("R5", 2'b11, a, PAT1);
      run("R5", 2'b11, a, PAT3);
    end
    run("R5", 2'b11, N + 7, PAT1);
    run("R9", 2'b11, N, PAT1);
    run("R9", 2'b11, 2 * N, PAT2);
    run("R9", 2'b11, 3 * N, PAT0);
  endtask

  task automatic t_edge_n;
    run("R6", 2'b00, N, PAT0);
    run("R6", 2'b00, N, PAT2);
    run("R6", 2'b01, N, PAT0);
    run("R6", 2'b01, N, PAT2);
  endtask

  task automatic t_beyond;
    run("R7", 2'b00, N + 1, 32'hFFFF_FFFF);
    run("R7", 2'b01, N + 1, 32'hFFFF_FFFF);
    run("R7", 2'b01, 255, PAT1);
    run("R8", 2'b10, N, PAT3);
    run("R8", 2'b10, N + 9, PAT3);
    run("R8", 2'b10, 200, PAT2);
  endtask

  task automatic t_latency;
    logic [N-1:0] held;
    run("R11", 2'b01, 4, PAT1);
    held = result;
    @(negedge clk);
    op = 2'b00; amount = 8'd8; operand = PAT3;
    #1;
    chk("R11", "holds before edge", result, held);
    @(negedge clk);
    chk("R11", "updates after edge", result, PAT3 << 8);
  endtask

  initial begin
    op = 2'b00; amount = '0; operand = '0;
    t_reset();
    t_zero();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_edge_n();
    t_beyond();
    t_latency();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule